// File: doc/BRIEF.md
# Processor Interrupt Delivery Controller

This block connects external interrupt sources to a processor core. Three kinds of request enter the block: a reset request, a non-maskable interrupt (NMI) and a maskable interrupt level that is 6 bits wide. The block holds each request in a pending flag. At every instruction boundary it picks one pending request by fixed priority. It then either pulses an exception request to the core or updates the hardware-pending field of the core's cause register.

The core supplies the global interrupt enable and the mask field of its status register as inputs on every cycle. A maskable level that is pending but blocked stays pending. It is evaluated again at each later boundary until it is taken or replaced. A level value of zero is an end-of-interrupt marker. It clears the cause pending field and raises no exception.

All outputs are registered. An exception or cause write that is decided at a boundary shows up on the outputs one clock after that boundary was sampled.

Top module: `irq_delivery_ctrl`

## Requirements
- R1: While and after a synchronous reset (`rst` high), all pending flags are clear, `cause_ip_o` is 0, and `cause_we_o`, `exc_rstnmi_o` and `exc_int_o` are 0.
- R2: A reset request is latched as pending. At the first later cycle with `boundary_i` high, `exc_rstnmi_o` goes high for one cycle and the request is consumed.
- R3: Priority is fixed: a pending reset is served before a pending NMI, and a pending NMI before a pending level. One request is served per boundary.
- R4: Serving a reset or an NMI leaves `cause_ip_o` unchanged and does not assert `cause_we_o`.
- R5: When a pending level is evaluated, `cause_ip_o` is loaded with the pending level value (bit i = level bit i) and `cause_we_o` pulses high for that cycle.
- R6: A level is taken only when `sr_ie_i` is 1 and (level AND `sr_im_i`) is nonzero. Taking it pulses `exc_int_o` and clears the pending level.
- R7: A nonzero level that is blocked by the enable or the mask stays pending. It rewrites the cause field at every later boundary and raises no exception until it is unblocked.
- R8: A level event with value 0 is an end-of-interrupt. At the next boundary `cause_ip_o` becomes 0, `cause_we_o` pulses, no exception is raised, and the marker is consumed.
- R9: A new level event replaces any level value still pending.
- R10: `exc_rstnmi_o` and `exc_int_o` are never high in the same cycle.
- R11: Without `boundary_i`, nothing is evaluated. No exception pulse or cause write occurs, and `cause_ip_o` holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rst_req_i | input | 1 | Reset request event (one-cycle strobe) |
| nmi_req_i | input | 1 | Non-maskable interrupt event (one-cycle strobe) |
| lvl_evt_i | input | 1 | Maskable level event strobe |
| lvl_i | input | IP_W | Level value carried by the event; 0 means end-of-interrupt |
| boundary_i | input | 1 | Instruction retirement strobe that enables evaluation |
| sr_ie_i | input | 1 | Status global interrupt enable |
| sr_im_i | input | IP_W | Status interrupt mask field |
| cause_ip_o | output | IP_W | Cause register hardware-pending field |
| cause_we_o | output | 1 | Write enable for the cause pending field |
| exc_rstnmi_o | output | 1 | Reset/NMI exception request pulse |
| exc_int_o | output | 1 | Interrupt exception request pulse |

## Verification
The bench queues a reset request, an NMI and a level all at once. It expects three separate services on consecutive boundaries, in that order. A design with the wrong order, or one that served two requests per boundary, would pulse the wrong output or merge the pulses. A level is held off first by a cleared enable and then by a mask with no overlapping bits. This catches a design that drops a blocked level after the first try, or that ignores the mask and takes the interrupt early. An end-of-interrupt marker must zero the cause field without an interrupt pulse, and a second level event must replace the first. A design that treated zero as a real level, or kept the stale value, would show the wrong cause bits. Cycles with no boundary strobe check that no pending request leaks out between instruction retirements.

// File: rtl/irq_dlv_pkg.sv
package irq_dlv_pkg;
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_RST  = 2'd1,
    SEL_NMI  = 2'd2,
    SEL_LVL  = 2'd3
  } sel_e;

  localparam int unsigned NUM_HARD = 2;  // reset and NMI flags
  localparam int unsigned IDX_RST  = 0;
  localparam int unsigned IDX_NMI  = 1;
endpackage

// File: rtl/irq_pend_flags.sv
module irq_pend_flags
  import irq_dlv_pkg::*;
#(
  parameter int unsigned IP_W = 6
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_HARD-1:0] hard_evt_i,
  input  logic [NUM_HARD-1:0] hard_clr_i,
  input  logic                lvl_evt_i,
  input  logic [IP_W-1:0]     lvl_i,
  input  logic                lvl_clr_i,
  output logic [NUM_HARD-1:0] hard_pend_o,
  output logic                lvl_pend_o,
  output logic [IP_W-1:0]     lvl_val_o
);
  // Reset and NMI flags: a new event outranks a clear in the same cycle
  for (genvar g = 0; g < NUM_HARD; g++) begin : g_hard
    always_ff @(posedge clk) begin
      if (rst) hard_pend_o[g] <= 1'b0;
      else     hard_pend_o[g] <= hard_evt_i[g] | (hard_pend_o[g] & ~hard_clr_i[g]);
    end
  end

  // Level slot: the most recent event overwrites any value still pending
  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_pend_o <= 1'b0;
      lvl_val_o  <= '0;
    end else if (lvl_evt_i) begin
      lvl_pend_o <= 1'b1;
      lvl_val_o  <= lvl_i;
    end else if (lvl_clr_i) begin
      lvl_pend_o <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_dlv_pkg::*;
#(
  parameter int unsigned IP_W = 6
) (
  input  logic                boundary_i,
  input  logic [NUM_HARD-1:0] hard_pend_i,
  input  logic                lvl_pend_i,
  input  logic [IP_W-1:0]     lvl_val_i,
  input  logic                sr_ie_i,
  input  logic [IP_W-1:0]     sr_im_i,
  output sel_e                sel_o,
  output logic                take_int_o,
  output logic [NUM_HARD-1:0] hard_clr_o,
  output logic                lvl_clr_o
);
  logic is_eoi;
  logic unmasked;

  assign is_eoi   = (lvl_val_i == '0);
  assign unmasked = sr_ie_i && ((lvl_val_i & sr_im_i) != '0);

  always_comb begin
    sel_o = SEL_NONE;
    if (boundary_i) begin
      if (hard_pend_i[IDX_RST])      sel_o = SEL_RST;
      else if (hard_pend_i[IDX_NMI]) sel_o = SEL_NMI;
      else if (lvl_pend_i)           sel_o = SEL_LVL;
    end
  end

  assign take_int_o          = (sel_o == SEL_LVL) && !is_eoi && unmasked;
  assign lvl_clr_o           = (sel_o == SEL_LVL) && (is_eoi || unmasked);
  assign hard_clr_o[IDX_RST] = (sel_o == SEL_RST);
  assign hard_clr_o[IDX_NMI] = (sel_o == SEL_NMI);
endmodule

// File: rtl/irq_out_reg.sv
module irq_out_reg
  import irq_dlv_pkg::*;
#(
  parameter int unsigned IP_W = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  sel_e            sel_i,
  input  logic            take_int_i,
  input  logic [IP_W-1:0] lvl_val_i,
  output logic [IP_W-1:0] cause_ip_o,
  output logic            cause_we_o,
  output logic            exc_rstnmi_o,
  output logic            exc_int_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cause_ip_o   <= '0;
      cause_we_o   <= 1'b0;
      exc_rstnmi_o <= 1'b0;
      exc_int_o    <= 1'b0;
    end else begin
      cause_we_o   <= (sel_i == SEL_LVL);
      exc_rstnmi_o <= (sel_i == SEL_RST) || (sel_i == SEL_NMI);
      exc_int_o    <= take_int_i;
      if (sel_i == SEL_LVL) cause_ip_o <= lvl_val_i;
    end
  end
endmodule

// File: rtl/irq_delivery_ctrl.sv
module irq_delivery_ctrl
  import irq_dlv_pkg::*;
#(
  parameter int unsigned IP_W = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            rst_req_i,
  input  logic            nmi_req_i,
  input  logic            lvl_evt_i,
  input  logic [IP_W-1:0] lvl_i,
  input  logic            boundary_i,
  input  logic            sr_ie_i,
  input  logic [IP_W-1:0] sr_im_i,
  output logic [IP_W-1:0] cause_ip_o,
  output logic            cause_we_o,
  output logic            exc_rstnmi_o,
  output logic            exc_int_o
);
  logic [NUM_HARD-1:0] hard_evt;
  logic [NUM_HARD-1:0] hard_pend;
  logic [NUM_HARD-1:0] hard_clr;
  logic                lvl_pend;
  logic [IP_W-1:0]     lvl_val;
  logic                lvl_clr;
  logic                take_int;
  sel_e                sel;

  assign hard_evt[IDX_RST] = rst_req_i;
  assign hard_evt[IDX_NMI] = nmi_req_i;

  irq_pend_flags #(.IP_W(IP_W)) u_flags (
    .clk         (clk),
    .rst         (rst),
    .hard_evt_i  (hard_evt),
    .hard_clr_i  (hard_clr),
    .lvl_evt_i   (lvl_evt_i),
    .lvl_i       (lvl_i),
    .lvl_clr_i   (lvl_clr),
    .hard_pend_o (hard_pend),
    .lvl_pend_o  (lvl_pend),
    .lvl_val_o   (lvl_val)
  );

  irq_arbiter #(.IP_W(IP_W)) u_arb (
    .boundary_i  (boundary_i),
    .hard_pend_i (hard_pend),
    .lvl_pend_i  (lvl_pend),
    .lvl_val_i   (lvl_val),
    .sr_ie_i     (sr_ie_i),
    .sr_im_i     (sr_im_i),
    .sel_o       (sel),
    .take_int_o  (take_int),
    .hard_clr_o  (hard_clr),
    .lvl_clr_o   (lvl_clr)
  );

  irq_out_reg #(.IP_W(IP_W)) u_out (
    .clk          (clk),
    .rst          (rst),
    .sel_i        (sel),
    .take_int_i   (take_int),
    .lvl_val_i    (lvl_val),
    .cause_ip_o   (cause_ip_o),
    .cause_we_o   (cause_we_o),
    .exc_rstnmi_o (exc_rstnmi_o),
    .exc_int_o    (exc_int_o)
  );
endmodule

// File: rtl/irq_delivery_ctrl_chk.sv
module irq_delivery_ctrl_chk #(
  parameter int unsigned IP_W = 6
) (
  input logic            clk,
  input logic            rst,
  input logic            boundary_i,
  input logic            sr_ie_i,
  input logic [IP_W-1:0] sr_im_i,
  input logic [IP_W-1:0] cause_ip_o,
  input logic            cause_we_o,
  input logic            exc_rstnmi_o,
  input logic            exc_int_o
);
  AST_ONE_EXC: assert property (@(posedge clk) disable iff (rst)
    !(exc_rstnmi_o && exc_int_o)); // R10

  AST_ONLY_AT_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
    (exc_rstnmi_o || exc_int_o || cause_we_o) |-> $past(boundary_i)); // R11

  AST_INT_GATED: assert property (@(posedge clk) disable iff (rst)
    exc_int_o |-> ($past(sr_ie_i) && (($past(sr_im_i) & cause_ip_o) != '0))); // R6

  AST_HARD_KEEPS_CAUSE: assert property (@(posedge clk) disable iff (rst)
    exc_rstnmi_o |-> (!cause_we_o && $stable(cause_ip_o))); // R4

  AST_INT_WRITES_CAUSE: assert property (@(posedge clk) disable iff (rst)
    exc_int_o |-> (cause_we_o && (cause_ip_o != '0))); // R5

  AST_EOI_SILENT: assert property (@(posedge clk) disable iff (rst)
    (cause_we_o && (cause_ip_o == '0)) |-> !exc_int_o); // R8

  AST_RESET_CLEAR: assert property (@(posedge clk)
    $past(rst) |-> (!exc_rstnmi_o && !exc_int_o && !cause_we_o && (cause_ip_o == '0))); // R1
endmodule

bind irq_delivery_ctrl irq_delivery_ctrl_chk #(.IP_W(IP_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .boundary_i   (boundary_i),
  .sr_ie_i      (sr_ie_i),
  .sr_im_i      (sr_im_i),
  .cause_ip_o   (cause_ip_o),
  .cause_we_o   (cause_we_o),
  .exc_rstnmi_o (exc_rstnmi_o),
  .exc_int_o    (exc_int_o)
);

// File: tb/irq_delivery_ctrl_tb.sv
`timescale 1ns/1ps
module irq_delivery_ctrl_tb;
  localparam int unsigned IP_W = 6;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            rst_req_i = 1'b0;
  logic            nmi_req_i = 1'b0;
  logic            lvl_evt_i = 1'b0;
  logic [IP_W-1:0] lvl_i = '0;
  logic            boundary_i = 1'b0;
  logic            sr_ie_i = 1'b0;
  logic [IP_W-1:0] sr_im_i = '0;
  logic [IP_W-1:0] cause_ip_o;
  logic            cause_we_o;
  logic            exc_rstnmi_o;
  logic            exc_int_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  irq_delivery_ctrl #(.IP_W(IP_W)) u_dut (
    .clk(clk), .rst(rst), .rst_req_i(rst_req_i), .nmi_req_i(nmi_req_i),
    .lvl_evt_i(lvl_evt_i), .lvl_i(lvl_i), .boundary_i(boundary_i),
    .sr_ie_i(sr_ie_i), .sr_im_i(sr_im_i), .cause_ip_o(cause_ip_o),
    .cause_we_o(cause_we_o), .exc_rstnmi_o(exc_rstnmi_o), .exc_int_o(exc_int_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Drive one cycle of inputs at the falling edge, then sample just after the rising edge
  task automatic cyc(input logic r, input logic n, input logic lv,
                     input logic [IP_W-1:0] l, input logic b);
    @(negedge clk);
    rst_req_i = r; nmi_req_i = n; lvl_evt_i = lv; lvl_i = l; boundary_i = b;
    @(posedge clk);
    #1;
  endtask

  task automatic outs(input string req, input logic hx, input logic ix,
                      input logic wx, input logic [IP_W-1:0] cx);
    chk({req, " exc_rstnmi"}, 32'(exc_rstnmi_o), 32'(hx));
    chk({req, " exc_int"},    32'(exc_int_o),    32'(ix));
    chk({req, " cause_we"},   32'(cause_we_o),   32'(wx));
    chk({req, " cause_ip"},   32'(cause_ip_o),   32'(cx));
  endtask

  task automatic t_reset();
    @(negedge clk); rst = 1'b1;
    cyc(0, 0, 0, '0, 0);
    cyc(0, 0, 0, '0, 1);
    outs("R1 in reset", 0, 0, 0, '0);
    @(negedge clk); rst = 1'b0;
    cyc(0, 0, 0, '0, 1);
    outs("R1 after reset", 0, 0, 0, '0);
  endtask

  task automatic t_reset_request();
    cyc(1, 0, 0, '0, 0);
    cyc(0, 0, 0, '0, 0);
    outs("R11 no boundary", 0, 0, 0, '0);
    cyc(0, 0, 0, '0, 1);
    outs("R2 reset served", 1, 0, 0, '0);
    cyc(0, 0, 0, '0, 1);
    outs("R2 consumed", 0, 0, 0, '0);
  endtask

  task automatic t_priority();
    sr_ie_i = 1'b1; sr_im_i = 6'h3F;
    cyc(1, 1, 1, 6'h01, 0);
    cyc(0, 0, 0, '0, 1);
    outs("R3 reset first R4", 1, 0, 0, '0);
    cyc(0, 0, 0, '0, 1);
    outs("R3 nmi second R4", 1, 0, 0, '0);
    chk("R10 one exception", 32'(exc_rstnmi_o & exc_int_o), 32'd0);
    cyc(0, 0, 0, '0, 1);
    outs("R3 level third R5 R6", 0, 1, 1, 6'h01);
    cyc(0, 0, 0, '0, 1);
    outs("R6 level consumed", 0, 0, 0, 6'h01);
  endtask

  task automatic t_blocked();
    sr_ie_i = 1'b0; sr_im_i = 6'h3F;
    cyc(0, 0, 1, 6'h24, 0);
    cyc(0, 0, 0, '0, 1);
    outs("R7 disabled first try", 0, 0, 1, 6'h24);
    cyc(0, 0, 0, '0, 1);
    outs("R7 disabled retry", 0, 0, 1, 6'h24);
    sr_ie_i = 1'b1; sr_im_i = 6'h03;
    cyc(0, 0, 0, '0, 1);
    outs("R6 R7 mask miss", 0, 0, 1, 6'h24);
    cyc(0, 0, 0, '0, 0);
    outs("R11 hold without boundary", 0, 0, 0, 6'h24);
    sr_im_i = 6'h04;
    cyc(0, 0, 0, '0, 1);
    outs("R6 unmasked taken", 0, 1, 1, 6'h24);
    cyc(0, 0, 0, '0, 1);
    outs("R6 taken then idle", 0, 0, 0, 6'h24);
  endtask

  task automatic t_eoi();
    cyc(0, 0, 1, 6'h00, 0);
    outs("R11 eoi waits", 0, 0, 0, 6'h24);
    cyc(0, 0, 0, '0, 1);
    outs("R8 eoi clears cause", 0, 0, 1, 6'h00);
    cyc(0, 0, 0, '0, 1);
    outs("R8 eoi consumed", 0, 0, 0, 6'h00);
  endtask

  task automatic t_replace();
    sr_ie_i = 1'b0;
    cyc(0, 0, 1, 6'h08, 0);
    cyc(0, 0, 1, 6'h10, 0);
    sr_ie_i = 1'b1; sr_im_i = 6'h10;
    cyc(0, 0, 0, '0, 1);
    outs("R9 newest level used", 0, 1, 1, 6'h10);
    cyc(0, 0, 0, '0, 1);
    outs("R9 old level gone", 0, 0, 0, 6'h10);
  endtask

  task automatic t_gating();
    sr_ie_i = 1'b1; sr_im_i = 6'h3F;
    cyc(0, 1, 1, 6'h02, 0);
    for (int i = 0; i < 3; i++) begin
      cyc(0, 0, 0, '0, 0);
      outs("R11 idle between boundaries", 0, 0, 0, 6'h10);
    end
    cyc(0, 0, 0, '0, 1);
    outs("R3 nmi before level", 1, 0, 0, 6'h10);
    cyc(0, 0, 0, '0, 0);
    outs("R2 single pulse", 0, 0, 0, 6'h10);
    cyc(0, 0, 0, '0, 1);
    outs("R5 level delivered", 0, 1, 1, 6'h02);
  endtask

  initial begin
    t_reset();
    t_reset_request();
    t_priority();
    t_blocked();
    t_eoi();
    t_replace();
    t_gating();
    cyc(0, 0, 0, '0, 0);
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule